// File: doc/BRIEF.md
# Banked Memory Mapper and Chip-Enable Decoder

This block sits on the bus of a 6502-style processor. It lets a resident firmware program and a loaded music program share one 64 kB address space. From the CPU address it produces three active-low chip selects: one for a character LCD, one for a 32 kB SRAM and one for a 512 kB flash. It also drives the upper address lines of both memories, so each program sees its own memory image.

A single context bit selects between firmware context and song context. The context bit swaps two things:
- the 2 kB of low RAM at $0000-$07FF, which holds the zero page, stack and variables;
- the ROM image seen at $8000-$FFFF.

The RAM window at $1000-$1FFF is identical in both contexts. Code placed there keeps running across a context switch, and also while the flash cannot be read. In song context the upper half of the map is cut into eight 4 kB windows. Each window has a 5-bit bank number, so a song of up to 128 kB can be paged in.

Software writes the bank numbers and the context bit at $5000-$500F. Offsets 0 to 7 hold the bank numbers and offset 8 holds the context bit. The block has no data streams, so every pin is a plain level signal with no handshake or back-pressure. The chip selects depend only on the present address and bus phase.

Top module: `bank_mapper`

## Requirements
- R1: After reset the context bit is 0 (firmware context) and all eight bank numbers are 0.
- R2: All three chip selects are active low. At most one is low at any time. All are high while `m2` is low.
- R3: With `m2` high, addresses $0000-$07FF assert `sram_ce_n`. `sram_hi` (SRAM A14..A11) is 4'b0000 in firmware context and 4'b0001 in song context.
- R4: With `m2` high, addresses $1000-$1FFF assert `sram_ce_n` in both contexts, and `sram_hi` equals address bits [14:11].
- R5: With `m2` high, addresses $6000-$7FFF assert `sram_ce_n`, and `sram_hi` equals address bits [14:11].
- R6: With `m2` high, addresses $3000-$3FFF assert `lcd_ce_n`. Addresses $0800-$0FFF, $2000-$2FFF and $4000-$5FFF assert no chip select.
- R7: With `m2` high, addresses $8000-$FFFF assert `flash_ce_n`. In firmware context `flash_hi` (flash A18..A12) is {FW_REGION[3:0], address[14:12]}.
- R8: In song context, `flash_hi` for an access at $8000-$FFFF is SONG_BASE plus the 5-bit bank number of window address[14:12], modulo 128.
- R9: A write takes effect at the next rising `clk` edge. A write is `m2` high and `rw` low with the address at $5000-$5007 or $5008. At $5000+k, `wr_data[4:0]` goes to bank k. At $5008, `wr_data[0]` goes to the context bit and the other data bits have no effect.
- R10: Several accesses leave every bank number and the context bit unchanged: reads of $5000-$500F, writes while `m2` is low, writes to $5009-$500F, and writes to $5010-$5FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; register writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | Bus phase; high while the address and data are valid |
| rw | input | 1 | 1 = CPU read, 0 = CPU write |
| addr | input | 16 | CPU address |
| wr_data | input | 5 | Low five bits of the CPU data bus |
| lcd_ce_n | output | 1 | LCD select, active low |
| sram_ce_n | output | 1 | SRAM select, active low |
| flash_ce_n | output | 1 | Flash select, active low |
| sram_hi | output | 4 | SRAM address bits A14..A11; meaningful while `sram_ce_n` is low |
| flash_hi | output | 7 | Flash address bits A18..A12; meaningful while `flash_ce_n` is low |

## Verification
The bench builds the block with SONG_BASE = 96 and FW_REGION = 1. With that base, bank 31 maps to the topmost flash page 127, which exercises the full width of the adder. With a non-zero firmware region, a firmware fetch can be told apart from a song fetch through bank 0 or from a stuck-at-zero address. Every one of the 65,536 addresses is swept in both contexts against randomly filled bank numbers. Directed cases cover the register-range accesses that must be ignored.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

  localparam int ADDR_W = 16;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_LOWRAM,
    RGN_COMMON,
    RGN_LCD,
    RGN_REGS,
    RGN_WRAM,
    RGN_ROM
  } region_e;

  // Coarse map: bit 15 picks ROM; below that, 4 kB pages by bits [14:12].
  function automatic region_e classify(input logic [ADDR_W-1:0] a);
    region_e r;
    if (a[ADDR_W-1]) begin
      r = RGN_ROM;
    end else begin
      case (a[14:12])
        3'd0:       r = a[11] ? RGN_NONE : RGN_LOWRAM;
        3'd1:       r = RGN_COMMON;
        3'd3:       r = RGN_LCD;
        3'd5:       r = RGN_REGS;
        3'd6, 3'd7: r = RGN_WRAM;
        default:    r = RGN_NONE;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/addr_decoder.sv
module addr_decoder
  import mapper_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int SA_W  = 4
) (
  input  logic              m2,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic              song_ctx,
  output logic              lcd_ce_n,
  output logic              sram_ce_n,
  output logic              flash_ce_n,
  output logic [SA_W-1:0]   sram_hi,
  output logic              reg_wr
);

  localparam int PAGE_MSB = 11;

  region_e region;
  logic    sram_sel;

  always_comb begin
    region   = classify(addr);
    sram_sel = (region == RGN_LOWRAM) || (region == RGN_COMMON) ||
               (region == RGN_WRAM);

    lcd_ce_n   = !(m2 && region == RGN_LCD);
    sram_ce_n  = !(m2 && sram_sel);
    flash_ce_n = !(m2 && region == RGN_ROM);

    // Register slots occupy the bottom 2**IDX_W bytes of the register page.
    reg_wr = m2 && !rw && (region == RGN_REGS) &&
             (addr[PAGE_MSB:IDX_W] == '0);

    // Low RAM is the only range whose physical page depends on context.
    if (region == RGN_LOWRAM && song_ctx)
      sram_hi = SA_W'(1);
    else
      sram_hi = addr[ADDR_W-2 -: SA_W];
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile #(
  parameter int N_WIN  = 8,
  parameter int BANK_W = 5,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [BANK_W-1:0]       wdata,
  output logic [N_WIN*BANK_W-1:0] banks_flat,
  output logic                    song_ctx
);

  localparam logic [IDX_W-1:0] CTX_IDX = IDX_W'(N_WIN);

  for (genvar g = 0; g < N_WIN; g++) begin : g_bank
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q <= '0;
      else if (wr_en && idx == IDX_W'(g))
        bank_q <= wdata;
    end

    assign banks_flat[g*BANK_W +: BANK_W] = bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      song_ctx <= 1'b0;
    else if (wr_en && idx == CTX_IDX)
      song_ctx <= wdata[0];
  end

endmodule

// File: rtl/flash_xlate.sv
module flash_xlate #(
  parameter int N_WIN     = 8,
  parameter int BANK_W    = 5,
  parameter int FA_W      = 7,
  parameter int SONG_BASE = 32,
  parameter int FW_REGION = 0
) (
  input  logic [$clog2(N_WIN)-1:0] win,
  input  logic [N_WIN*BANK_W-1:0]  banks_flat,
  input  logic                     song_ctx,
  output logic [FA_W-1:0]          flash_hi
);

  localparam int WIN_W = $clog2(N_WIN);
  localparam int FW_W  = FA_W - WIN_W;
  localparam logic [FA_W-1:0] BASE_V = FA_W'(SONG_BASE);
  localparam logic [FW_W-1:0] FW_V   = FW_W'(FW_REGION);

  logic [BANK_W-1:0] bank_sel;

  always_comb begin
    bank_sel = banks_flat[win*BANK_W +: BANK_W];
    if (song_ctx)
      flash_hi = BASE_V + FA_W'(bank_sel);
    else
      flash_hi = {FW_V, win};
  end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import mapper_pkg::*;
#(
  parameter int N_WIN     = 8,
  parameter int BANK_W    = 5,
  parameter int FA_W      = 7,
  parameter int SA_W      = 4,
  parameter int SONG_BASE = 32,
  parameter int FW_REGION = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m2,
  input  logic              rw,
  input  logic [15:0]       addr,
  input  logic [BANK_W-1:0] wr_data,
  output logic              lcd_ce_n,
  output logic              sram_ce_n,
  output logic              flash_ce_n,
  output logic [SA_W-1:0]   sram_hi,
  output logic [FA_W-1:0]   flash_hi
);

  localparam int IDX_W   = $clog2(N_WIN + 1);
  localparam int WIN_W   = $clog2(N_WIN);
  localparam int WIN_LSB = ADDR_W - 1 - WIN_W;

  logic                    song_ctx;
  logic                    reg_wr;
  logic [N_WIN*BANK_W-1:0] banks_flat;

  addr_decoder #(
    .IDX_W (IDX_W),
    .SA_W  (SA_W)
  ) u_dec (
    .m2         (m2),
    .rw         (rw),
    .addr       (addr),
    .song_ctx   (song_ctx),
    .lcd_ce_n   (lcd_ce_n),
    .sram_ce_n  (sram_ce_n),
    .flash_ce_n (flash_ce_n),
    .sram_hi    (sram_hi),
    .reg_wr     (reg_wr)
  );

  bank_regfile #(
    .N_WIN  (N_WIN),
    .BANK_W (BANK_W),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .idx        (addr[IDX_W-1:0]),
    .wdata      (wr_data),
    .banks_flat (banks_flat),
    .song_ctx   (song_ctx)
  );

  flash_xlate #(
    .N_WIN     (N_WIN),
    .BANK_W    (BANK_W),
    .FA_W      (FA_W),
    .SONG_BASE (SONG_BASE),
    .FW_REGION (FW_REGION)
  ) u_xlate (
    .win        (addr[WIN_LSB +: WIN_W]),
    .banks_flat (banks_flat),
    .song_ctx   (song_ctx),
    .flash_hi   (flash_hi)
  );

endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int N_WIN = 8,
  parameter int IDX_W = 4,
  parameter int SA_W  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            m2,
  input logic [15:0]     addr,
  input logic            wr_bit0,
  input logic            lcd_ce_n,
  input logic            sram_ce_n,
  input logic            flash_ce_n,
  input logic [SA_W-1:0] sram_hi,
  input logic            song_ctx,
  input logic            reg_wr
);

  logic ctx_hit;
  assign ctx_hit = reg_wr && (addr[IDX_W-1:0] == IDX_W'(N_WIN));

  // R2
  one_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~lcd_ce_n, ~sram_ce_n, ~flash_ce_n}));

  // R2
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m2 |-> (lcd_ce_n && sram_ce_n && flash_ce_n));

  // R7
  rom_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 && addr[15]) |-> !flash_ce_n);

  // R3
  low_ram_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 && addr[15:11] == 5'd0) |-> (!sram_ce_n && sram_hi[0] == song_ctx));

  // R9
  ctx_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_hit |=> (song_ctx == $past(wr_bit0)));

  // R10
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_hit |=> $stable(song_ctx));

endmodule

bind bank_mapper bank_mapper_chk #(
  .N_WIN (N_WIN),
  .IDX_W (IDX_W),
  .SA_W  (SA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .m2         (m2),
  .addr       (addr),
  .wr_bit0    (wr_data[0]),
  .lcd_ce_n   (lcd_ce_n),
  .sram_ce_n  (sram_ce_n),
  .flash_ce_n (flash_ce_n),
  .sram_hi    (sram_hi),
  .song_ctx   (song_ctx),
  .reg_wr     (reg_wr)
);

// File: tb/test_bank_mapper.sv
module test_bank_mapper;

  localparam int CLK_P     = 10;
  localparam int SONG_BASE = 96;
  localparam int FW_REGION = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        m2;
  logic        rw;
  logic [15:0] addr;
  logic [4:0]  wr_data;
  logic        lcd_ce_n, sram_ce_n, flash_ce_n;
  logic [3:0]  sram_hi;
  logic [6:0]  flash_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bit [4:0] mb [8];
  bit       mctx;

  always #(CLK_P/2) clk = ~clk;

  bank_mapper #(
    .SONG_BASE (SONG_BASE),
    .FW_REGION (FW_REGION)
  ) i_bank_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .m2         (m2),
    .rw         (rw),
    .addr       (addr),
    .wr_data    (wr_data),
    .lcd_ce_n   (lcd_ce_n),
    .sram_ce_n  (sram_ce_n),
    .flash_ce_n (flash_ce_n),
    .sram_hi    (sram_hi),
    .flash_hi   (flash_hi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h: actual %0h expected %0h", req, addr, act, exp);
    end
  endtask

  // Expected {lcd_n, sram_n, flash_n}
  function automatic logic [2:0] exp_en(input logic [15:0] a, input logic ph);
    if (!ph)                             return 3'b111;
    if (a >= 16'h8000)                   return 3'b110;
    if (a < 16'h0800)                    return 3'b101;
    if (a >= 16'h1000 && a < 16'h2000)   return 3'b101;
    if (a >= 16'h6000)                   return 3'b101;
    if (a >= 16'h3000 && a < 16'h4000)   return 3'b011;
    return 3'b111;
  endfunction

  function automatic logic [3:0] exp_sram(input logic [15:0] a);
    if (a < 16'h0800) return mctx ? 4'b0001 : 4'b0000;
    return a[14:11];
  endfunction

  function automatic logic [6:0] exp_flash(input logic [15:0] a);
    logic [6:0] s;
    if (mctx) begin
      s = 7'(SONG_BASE) + {2'b00, mb[a[14:12]]};
      return s;
    end
    return {4'(FW_REGION), a[14:12]};
  endfunction

  function automatic string tag_of(input logic [15:0] a);
    if (a >= 16'h8000) return mctx ? "R8" : "R7";
    if (a < 16'h0800)  return "R3";
    if (a >= 16'h1000 && a < 16'h2000) return "R4";
    if (a >= 16'h6000) return "R5";
    return "R6";
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [4:0] d);
    @(negedge clk);
    addr = a; wr_data = d; rw = 1'b0; m2 = 1'b1;
    @(negedge clk);
    m2 = 1'b0; rw = 1'b1;
  endtask

  task automatic set_bank(input int k, input logic [4:0] v);
    bus_wr(16'h5000 + 16'(k), v);
    mb[k] = v;
  endtask

  task automatic set_ctx(input logic [4:0] v);
    bus_wr(16'h5008, v);
    mctx = v[0];
  endtask

  task automatic chk_windows(input string req);
    @(negedge clk);
    m2 = 1'b1; rw = 1'b1;
    for (int k = 0; k < 8; k++) begin
      addr = {1'b1, 3'(k), 12'h0A5};
      #1;
      chk(req, flash_hi, exp_flash(addr));
    end
    m2 = 1'b0;
  endtask

  task automatic sweep();
    @(negedge clk);
    m2 = 1'b1; rw = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      string t;
      addr = 16'(i);
      #1;
      t = tag_of(addr);
      chk({t, " enables"}, {lcd_ce_n, sram_ce_n, flash_ce_n}, exp_en(addr, 1'b1));
      if (!sram_ce_n)  chk({t, " sram_hi"}, sram_hi, exp_sram(addr));
      if (!flash_ce_n) chk({t, " flash_hi"}, flash_hi, exp_flash(addr));
    end
    m2 = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; m2 = 1'b0; rw = 1'b1; addr = 16'h0000; wr_data = '0;
    mctx = 1'b0;
    for (int k = 0; k < 8; k++) mb[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: idle phase keeps everything deselected
    addr = 16'h8000; #1;
    chk("R2 idle", {lcd_ce_n, sram_ce_n, flash_ce_n}, 3'b111);
    // R1: firmware context after reset
    m2 = 1'b1; #1;
    chk("R1 fw ctx", flash_hi, {4'(FW_REGION), 3'd0});
    addr = 16'h0010; #1;
    chk("R1 low ram page", sram_hi, 4'b0000);
    m2 = 1'b0;
    // R1: all banks zero
    set_ctx(5'd1);
    chk_windows("R1 banks zero");

    // R10: register write itself selects nothing
    @(negedge clk);
    addr = 16'h5003; rw = 1'b0; m2 = 1'b1; wr_data = 5'd7; #1;
    chk("R10 no select on reg write", {lcd_ce_n, sram_ce_n, flash_ce_n}, 3'b111);
    @(negedge clk); m2 = 1'b0; rw = 1'b1;
    mb[3] = 5'd7;
    chk_windows("R9 bank write");

    // R8: extremes of the bank range
    set_bank(0, 5'd31);
    set_bank(7, 5'd0);
    chk_windows("R8 extremes");

    // Random bank contents, full sweeps in both contexts
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 8; k++) set_bank(k, 5'($urandom));
      set_ctx(5'd0);
      sweep();
      set_ctx(5'd1);
      sweep();
    end

    // R2: random probes with m2 low
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      addr = 16'($urandom); m2 = 1'b0; rw = 1'($urandom); #1;
      chk("R2 idle random", {lcd_ce_n, sram_ce_n, flash_ce_n}, 3'b111);
    end
    rw = 1'b1;

    // R10: write with m2 low
    @(negedge clk);
    addr = 16'h5002; wr_data = ~mb[2]; rw = 1'b0; m2 = 1'b0;
    @(negedge clk); rw = 1'b1;
    chk_windows("R10 m2 low write");
    // R10: read of the register range
    @(negedge clk);
    addr = 16'h5005; wr_data = ~mb[5]; rw = 1'b1; m2 = 1'b1;
    @(negedge clk); m2 = 1'b0;
    chk_windows("R10 read ignored");
    // R10: unused slots and addresses above the slot range
    bus_wr(16'h5009, 5'd0);
    bus_wr(16'h500F, 5'd0);
    bus_wr(16'h5010, 5'h1F);
    bus_wr(16'h5FF1, 5'h1F);
    chk_windows("R10 unused slots");

    // R9: only bit 0 sets the context
    set_ctx(5'b11110);
    chk_windows("R9 ctx bit0");
    @(negedge clk);
    addr = 16'h0123; m2 = 1'b1; #1;
    chk("R9 ctx bit0 sram", sram_hi, 4'b0000);
    m2 = 1'b0;
    set_ctx(5'b00001);
    @(negedge clk);
    addr = 16'h07FF; m2 = 1'b1; #1;
    chk("R3 song low ram", sram_hi, 4'b0001);
    addr = 16'h1800; #1;
    chk("R4 common in song ctx", sram_hi, 4'b0011);
    addr = 16'h3ABC; #1;
    chk("R6 lcd", {lcd_ce_n, sram_ce_n, flash_ce_n}, 3'b011);
    addr = 16'h0800; #1;
    chk("R6 hole", {lcd_ce_n, sram_ce_n, flash_ce_n}, 3'b111);
    m2 = 1'b0;

    done = 1'b1;
    finish_run();
  end

endmodule